// File: doc/BRIEF.md
# Fractional Scale Multiplier

This block forms a scaled fixed-point product from two 32-bit operands and offers it as a one-shot replacement for the source operand of the instruction issued next. Only the lower half-word of each operand takes part. In unsigned mode the product is shifted right by a full half-word, which gives a 16.16 style fraction scaling. In signed mode both half-words are treated as two's-complement values. The product is then shifted right arithmetically by 14 places, so the result rounds toward minus infinity instead of toward zero.

A start strobe computes the result and latches it in a single cycle. From the following cycle the override output carries a valid flag. The issue logic samples this flag with the next instruction it issues. Once that instruction has consumed the value, the flag drops. Fetching operands and sequencing instructions are left to the surrounding pipeline.

Top module: `qscale_mul`

## Requirements
- R1: After reset `ovr_valid_o` is 0 and `ovr_data_o` is 0.
- R2: Bits 31:16 of `opa_i` and `opb_i` have no effect on the result.
- R3: With `mode_i` = 0 (unsigned), the result is (opa_i[15:0] * opb_i[15:0]) shifted right by 16 and zero-extended to 32 bits, so bits 31:16 are 0.
- R4: With `mode_i` = 1 (signed), both low halves are sign-extended from bit 15. Their product is shifted right arithmetically by 14, which equals floor(product / 16384). The result is sign-extended to 32 bits, so bits 31:17 all equal bit 17.
- R5: In signed mode, 1 times 0xFFFF (minus one) yields 0xFFFFFFFF, not 0.
- R6: A cycle with `start_i` = 1 loads the result. In the next cycle `ovr_valid_o` is 1 and `ovr_data_o` holds the result.
- R7: A cycle with `ovr_valid_o` = 1, `consume_i` = 1 and `start_i` = 0 makes `ovr_valid_o` 0 in the next cycle, so exactly one instruction sees the override.
- R8: While neither `start_i` nor `consume_i` is asserted, `ovr_valid_o` and `ovr_data_o` keep their values.
- R9: `consume_i` while `ovr_valid_o` is 0 has no effect: the flag stays 0 and the data is unchanged.
- R10: When `start_i` and `consume_i` are both 1, the new result wins. `ovr_valid_o` stays 1 and carries the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 32 | First operand; only bits 15:0 used |
| opb_i | input | 32 | Second operand; only bits 15:0 used |
| mode_i | input | 1 | 0 = unsigned scaling, 1 = signed scaling |
| start_i | input | 1 | Compute and latch a new override value |
| consume_i | input | 1 | The next instruction is issued and takes the override |
| ovr_data_o | output | 32 | Scaled result for the next source operand |
| ovr_valid_o | output | 1 | Override pending |

## Verification
On every cycle the assertions check the flag protocol: load on start, a single clear on consume, holding while idle, and no effect from a stray consume. They also check the shape of each fresh result, with zero upper bits in unsigned mode and a uniform sign field in signed mode. Whether the number itself is right can only be shown by the bench. It sweeps corner and spread half-word values in both modes against products computed with floor division, and it inserts random upper bits to show that those bits are ignored.

// File: rtl/qscale_pkg.sv
package qscale_pkg;
  typedef enum logic {
    QS_UNSIGNED = 1'b0,
    QS_SIGNED   = 1'b1
  } qs_mode_e;

  localparam int QS_OP_W_DEF   = 32;
  localparam int QS_HALF_W_DEF = 16;
  localparam int QS_USHIFT_DEF = 16;
  localparam int QS_SSHIFT_DEF = 14;
endpackage

// File: rtl/qscale_operand.sv
module qscale_operand #(
  parameter int OP_W   = 32,
  parameter int HALF_W = 16,
  parameter int EXT_W  = 32
) (
  input  logic [OP_W-1:0]  op_i,
  input  qscale_pkg::qs_mode_e mode_i,
  output logic [EXT_W-1:0] ext_o
);
  localparam int PAD_W = EXT_W - HALF_W;

  function automatic logic [EXT_W-1:0] widen(input logic [HALF_W-1:0] h,
                                             input logic sgn);
    logic fill;
    fill = sgn & h[HALF_W-1];
    return {{PAD_W{fill}}, h};
  endfunction

  assign ext_o = widen(op_i[HALF_W-1:0], mode_i == qscale_pkg::QS_SIGNED);
endmodule

// File: rtl/qscale_core.sv
module qscale_core #(
  parameter int OP_W   = 32,
  parameter int HALF_W = 16,
  parameter int USHIFT = 16,
  parameter int SSHIFT = 14
) (
  input  logic [2*HALF_W-1:0] ext_a_i,
  input  logic [2*HALF_W-1:0] ext_b_i,
  input  qscale_pkg::qs_mode_e mode_i,
  output logic [2*HALF_W-1:0] prod_o,
  output logic [OP_W-1:0]     result_o
);
  localparam int PROD_W = 2 * HALF_W;
  localparam int WIDE_W = OP_W + PROD_W;

  function automatic logic [PROD_W-1:0] mul_low(input logic [PROD_W-1:0] a,
                                                input logic [PROD_W-1:0] b);
    logic signed [PROD_W-1:0] p;
    p = $signed(a) * $signed(b);
    return p;
  endfunction

  function automatic logic [OP_W-1:0] scale(input logic [PROD_W-1:0] p,
                                            input logic sgn);
    logic signed [PROD_W-1:0] sh_s;
    logic [PROD_W-1:0]        sh_u;
    logic [WIDE_W-1:0]        wide;
    sh_s = $signed(p) >>> SSHIFT;
    sh_u = p >> USHIFT;
    if (sgn) wide = {{OP_W{sh_s[PROD_W-1]}}, sh_s};
    else     wide = {{OP_W{1'b0}}, sh_u};
    return wide[OP_W-1:0];
  endfunction

  assign prod_o   = mul_low(ext_a_i, ext_b_i);
  assign result_o = scale(prod_o, mode_i == qscale_pkg::QS_SIGNED);
endmodule

// File: rtl/qscale_ovr_reg.sv
module qscale_ovr_reg #(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            retire_i,
  input  logic [OP_W-1:0] din_i,
  output logic [OP_W-1:0] data_o,
  output logic            valid_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (load_i) begin
        data_o  <= din_i;
        valid_o <= 1'b1;
      end else if (retire_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qscale_mul.sv
module qscale_mul #(
  parameter int OP_W   = 32,
  parameter int HALF_W = 16,
  parameter int USHIFT = 16,
  parameter int SSHIFT = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opa_i,
  input  logic [OP_W-1:0] opb_i,
  input  logic            mode_i,
  input  logic            start_i,
  input  logic            consume_i,
  output logic [OP_W-1:0] ovr_data_o,
  output logic            ovr_valid_o
);
  import qscale_pkg::*;

  localparam int PROD_W = 2 * HALF_W;
  localparam int N_OPS  = 2;

  qs_mode_e            mode;
  logic [OP_W-1:0]     op_raw [N_OPS];
  logic [PROD_W-1:0]   op_ext [N_OPS];
  logic [PROD_W-1:0]   prod;
  logic [OP_W-1:0]     result;

  // named events for the checker
  logic load_evt;
  logic retire_evt;
  logic stray_evt;

  assign mode      = qs_mode_e'(mode_i);
  assign op_raw[0] = opa_i;
  assign op_raw[1] = opb_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_opnd
    qscale_operand #(
      .OP_W  (OP_W),
      .HALF_W(HALF_W),
      .EXT_W (PROD_W)
    ) u_opnd (
      .op_i  (op_raw[g]),
      .mode_i(mode),
      .ext_o (op_ext[g])
    );
  end

  qscale_core #(
    .OP_W  (OP_W),
    .HALF_W(HALF_W),
    .USHIFT(USHIFT),
    .SSHIFT(SSHIFT)
  ) u_core (
    .ext_a_i (op_ext[0]),
    .ext_b_i (op_ext[1]),
    .mode_i  (mode),
    .prod_o  (prod),
    .result_o(result)
  );

  assign load_evt   = start_i;
  assign retire_evt = consume_i & ovr_valid_o & ~start_i;
  assign stray_evt  = consume_i & ~ovr_valid_o & ~start_i;

  qscale_ovr_reg #(
    .OP_W(OP_W)
  ) u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_evt),
    .retire_i(retire_evt),
    .din_i   (result),
    .data_o  (ovr_data_o),
    .valid_o (ovr_valid_o)
  );
endmodule

// File: rtl/qscale_mul_chk.sv
module qscale_mul_chk #(
  parameter int OP_W   = 32,
  parameter int HALF_W = 16,
  parameter int SSHIFT = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_i,
  input logic            start_i,
  input logic            consume_i,
  input logic            stray_evt,
  input logic [OP_W-1:0] ovr_data_o,
  input logic            ovr_valid_o
);
  localparam int SIGN_LSB = 2 * HALF_W - SSHIFT - 1;
  localparam int SIGN_W   = OP_W - SIGN_LSB;

  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ovr_valid_o); // R6
  AST_ONE_CONSUMER: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid_o && consume_i && !start_i) |=> !ovr_valid_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !consume_i) |=> ($stable(ovr_valid_o) && $stable(ovr_data_o))); // R8
  AST_STRAY_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    stray_evt |=> (!ovr_valid_o && $stable(ovr_data_o))); // R9
  AST_UNSIGNED_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !mode_i) |=> (ovr_data_o[OP_W-1:HALF_W] == '0)); // R3
  AST_SIGNED_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_i) |=> (ovr_data_o[OP_W-1:SIGN_LSB] == '0 ||
                             ovr_data_o[OP_W-1:SIGN_LSB] == {SIGN_W{1'b1}})); // R4
endmodule

bind qscale_mul qscale_mul_chk #(
  .OP_W  (OP_W),
  .HALF_W(HALF_W),
  .SSHIFT(SSHIFT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .start_i    (start_i),
  .consume_i  (consume_i),
  .stray_evt  (stray_evt),
  .ovr_data_o (ovr_data_o),
  .ovr_valid_o(ovr_valid_o)
);

// File: tb/qscale_mul_tb.sv
module qscale_mul_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT       = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        mode = 1'b0;
  logic        start = 1'b0;
  logic        consume = 1'b0;
  logic [31:0] ovr_data;
  logic        ovr_valid;

  int n_chk  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qscale_mul u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .opa_i      (opa),
    .opb_i      (opb),
    .mode_i     (mode),
    .start_i    (start),
    .consume_i  (consume),
    .ovr_data_o (ovr_data),
    .ovr_valid_o(ovr_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_val(input logic [15:0] a, input logic [15:0] b,
                                            input logic sgn);
    longint sa, sb, p, q;
    if (!sgn) begin
      p = longint'(a) * longint'(b);
      q = p / 65536;
    end else begin
      sa = (a >= 16'h8000) ? longint'(a) - 65536 : longint'(a);
      sb = (b >= 16'h8000) ? longint'(b) - 65536 : longint'(b);
      p  = sa * sb;
      if (p >= 0) q = p / 16384;
      else        q = -((-p + 16383) / 16384);
    end
    return q[31:0];
  endfunction

  function automatic logic [15:0] pat(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'h8001;
      6: return 16'hFFFE;
      7: return 16'hFFFF;
      default: return 16'(i * 16'h1D3B + 16'h0517);
    endcase
  endfunction

  function automatic logic [15:0] junk(input int i);
    logic [31:0] h;
    h = 32'(i) * 32'h9E3779B1;
    return h[31:16];
  endfunction

  // Start an operation and sample one cycle after the loading edge
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic cons);
    @(negedge clk);
    opa = a; opb = b; mode = s; start = 1'b1; consume = cons;
    @(negedge clk);
    start = 1'b0; consume = 1'b0;
  endtask

  task automatic retire;
    @(negedge clk);
    consume = 1'b1;
    @(negedge clk);
    consume = 1'b0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, ovr_valid}, 32'd0);
    check("R1 data", ovr_data, 32'd0);
    rst_n = 1'b1;

    // R9: stray consume before anything is loaded
    retire();
    check("R9 valid", {31'b0, ovr_valid}, 32'd0);
    check("R9 data", ovr_data, 32'd0);

    // R5 and named corners
    run_op(32'h0000_0001, 32'h0000_FFFF, 1'b1, 1'b0);
    check("R5 one times minus one", ovr_data, 32'hFFFF_FFFF);
    run_op(32'h0000_8000, 32'h0000_8000, 1'b1, 1'b0);
    check("R4 min times min", ovr_data, 32'h0001_0000);
    run_op(32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 1'b0);
    check("R3 max unsigned", ovr_data, 32'h0000_FFFE);
    run_op(32'hABCD_0002, 32'h1234_4000, 1'b1, 1'b0);
    check("R2 upper ignored signed", ovr_data, 32'h0000_0002);
    run_op(32'hFFFF_8000, 32'h5A5A_0002, 1'b0, 1'b0);
    check("R2 upper ignored unsigned", ovr_data, 32'h0000_0001);

    // R8: idle hold over several cycles
    held = ovr_data;
    repeat (5) @(negedge clk);
    check("R8 valid held", {31'b0, ovr_valid}, 32'd1);
    check("R8 data held", ovr_data, held);

    // R7: one consume clears; second consume is stray (R9)
    retire();
    check("R7 valid cleared", {31'b0, ovr_valid}, 32'd0);
    retire();
    check("R9 stray keeps valid low", {31'b0, ovr_valid}, 32'd0);
    check("R9 stray keeps data", ovr_data, held);

    // R10: start and consume together while valid
    run_op(32'h0000_0100, 32'h0000_0300, 1'b0, 1'b0);
    run_op(32'h0000_4000, 32'h0000_C000, 1'b1, 1'b1);
    check("R10 valid stays", {31'b0, ovr_valid}, 32'd1);
    check("R10 new data", ovr_data, expect_val(16'h4000, 16'hC000, 1'b1));

    // Sweep both modes over corner and spread patterns
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < NPAT; i++) begin
        for (int j = 0; j < NPAT; j++) begin
          run_op({junk(i * NPAT + j), pat(i)}, {junk(j * 7 + i + 3), pat(j)}, m[0], 1'b0);
          check(m[0] ? "R4 signed sweep" : "R3 unsigned sweep", ovr_data,
                expect_val(pat(i), pat(j), m[0]));
          check("R6 valid after start", {31'b0, ovr_valid}, 32'd1);
          retire();
          check("R7 cleared after one consume", {31'b0, ovr_valid}, 32'd0);
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule